// File: doc/BRIEF.md
# Block-Move Address Sequencer

This sequencer turns one block-transfer operation into a stream of doubleword memory accesses. A load-multiple reads a run of consecutive doublewords. A store-multiple writes such a run. A memory-to-memory move copies a run from a source region to a destination region through a single memory port. It does this by alternating one read of the source with one write of the destination.

Each access travels with two gating flags. The first asks the cache for a tag lookup and the second asks the translation buffer for a lookup. A stream raises each flag only on its first access and on the first access that enters a new cache line or page. Accesses inside the same line therefore reuse the previous tag result, and accesses inside the same page reuse the previous translation. One access issues per cycle unless the memory side stalls, so the block keeps pace with an equivalent sequence of single loads and stores.

Top module: `blk_move_seq`

## Requirements
- R1: After reset, and while no operation is running, `rd_o`, `wr_o`, `tag_en_o`, `tlb_en_o` and `done_o` are low.
- R2: Operation code 2'b01 (load) produces `count_i` read accesses with `rd_o` high and `wr_o` low. The addresses are consecutive doublewords starting at `src_addr_i`, with its three low bits taken as zero.
- R3: Operation code 2'b10 (store) produces `count_i` write accesses with `wr_o` high and `rd_o` low. The addresses follow the same sequence as in R2.
- R4: Operation code 2'b11 (move) produces 2×`count_i` accesses. They alternate between a read of the next source doubleword and a write of the next destination doubleword, starting with a read. `rd_o` and `wr_o` are never high together.
- R5: `tag_en_o` is high on the first access of each stream. It is also high on any access whose 2^LINE_LG-byte line differs from that of the previous access of the same stream, and low otherwise. Each stream therefore gets exactly one tag lookup per distinct line it touches.
- R6: `tlb_en_o` follows the rule of R5 for 2^PAGE_LG-byte pages.
- R7: The first access is presented in the cycle after the operation is accepted. Every cycle without `stall_i` completes one access, with no idle cycle before the last one.
- R8: While `stall_i` is high, `addr_o`, `rd_o`, `wr_o`, `tag_en_o` and `tlb_en_o` hold their values and the sequence does not advance.
- R9: `done_o` is high for one cycle, in the cycle after the last access completes. In that cycle no strobe is high.
- R10: A count of zero, or operation code 2'b00, raises `done_o` in the cycle after acceptance, with no strobe and no lookup.
- R11: `start_i` is ignored while an operation is running. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a new operation when idle |
| op_i | input | 2 | Operation: 00 none, 01 load, 10 store, 11 move |
| src_addr_i | input | ADDR_W | Start address (source for a move) |
| dst_addr_i | input | ADDR_W | Destination address for a move |
| count_i | input | CNT_W | Number of doublewords |
| stall_i | input | 1 | Memory side cannot take an access this cycle |
| addr_o | output | ADDR_W | Access address |
| rd_o | output | 1 | Read access |
| wr_o | output | 1 | Write access |
| tag_en_o | output | 1 | Cache tag lookup required |
| tlb_en_o | output | 1 | Translation lookup required |
| done_o | output | 1 | Operation finished |

## Verification
The bench builds the block with 64-byte lines and 512-byte pages, with LINE_LG=6 and PAGE_LG=9 in place of 4 KiB pages. Runs of up to a hundred or so doublewords then cross several pages as well as many lines. This brings page crossings, line crossings inside one page, and moves whose two streams cross at different moments within reach in short runs. Random stalls land on crossing accesses and on the last access, which exercises the hold and done timing at those points.

// File: rtl/blk_move_pkg.sv
package blk_move_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_MOVE  = 2'b11
  } blk_op_e;
endpackage

// File: rtl/blk_move_stream.sv
module blk_move_stream #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_LG = 3,
  parameter int unsigned LINE_LG = 6,
  parameter int unsigned PAGE_LG = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tag_need_o,
  output logic              tlb_need_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_LG;

  logic [ADDR_W-1:0] ptr_q;
  logic              first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      ptr_q   <= {addr_i[ADDR_W-1:WORD_LG], {WORD_LG{1'b0}}};
      first_q <= 1'b1;
    end else if (adv_i) begin
      ptr_q   <= ptr_q + STEP;
      first_q <= 1'b0;
    end
  end

  // sequential doubleword steps: a new line/page starts where the offset wraps to zero
  assign addr_o     = ptr_q;
  assign tag_need_o = first_q | (ptr_q[LINE_LG-1:WORD_LG] == '0);
  assign tlb_need_o = first_q | (ptr_q[PAGE_LG-1:WORD_LG] == '0);

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> addr_o == $past(addr_o) + STEP); // R2
  AST_TAG_NEW_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> (addr_o[ADDR_W-1:LINE_LG] == $past(addr_o[ADDR_W-1:LINE_LG])) || tag_need_o); // R5
  AST_TLB_NEW_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> (addr_o[ADDR_W-1:PAGE_LG] == $past(addr_o[ADDR_W-1:PAGE_LG])) || tlb_need_o); // R6
  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tag_need_o && tlb_need_o && addr_o[WORD_LG-1:0] == '0); // R5
endmodule

// File: rtl/blk_move_ctrl.sv
module blk_move_ctrl
  import blk_move_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  blk_op_e          op_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             stall_i,
  output logic             active_o,
  output blk_op_e          op_o,
  output logic             wr_phase_o,
  output logic             load_o,
  output logic             src_adv_o,
  output logic             dst_adv_o,
  output logic             done_o
);
  logic             active_q, phase_q, done_q;
  blk_op_e          op_q;
  logic [CNT_W-1:0] rem_q;
  logic             accept, step, word_end, last;

  assign accept   = start_i & ~active_q;
  assign step     = active_q & ~stall_i;
  assign word_end = (op_q != OP_MOVE) | phase_q;
  assign last     = word_end & (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_NONE;
      rem_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q    <= op_i;
        phase_q <= 1'b0;
        rem_q   <= count_i;
        if (op_i == OP_NONE || count_i == '0) done_q <= 1'b1;
        else active_q <= 1'b1;
      end else if (step) begin
        if (last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
        if (op_q == OP_MOVE) phase_q <= ~phase_q;
        if (word_end) rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign active_o   = active_q;
  assign op_o       = op_q;
  assign wr_phase_o = phase_q;
  assign load_o     = accept;
  assign src_adv_o  = step & ~phase_q;
  assign dst_adv_o  = step & phase_q;
  assign done_o     = done_q;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_q); // R9
  AST_ZERO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (count_i == '0) |=> done_o && !active_o); // R10
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && stall_i |=> active_q && rem_q == $past(rem_q) && phase_q == $past(phase_q)); // R8
  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && start_i && !last |=> active_q && op_q == $past(op_q)); // R11
endmodule

// File: rtl/blk_move_seq.sv
module blk_move_seq
  import blk_move_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WORD_LG = 3,
  parameter int unsigned LINE_LG = 6,
  parameter int unsigned PAGE_LG = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              stall_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              tag_en_o,
  output logic              tlb_en_o,
  output logic              done_o
);
  localparam int unsigned N_STREAM = 2; // 0: source, 1: destination

  logic    active, wr_phase, load;
  blk_op_e op;
  logic [N_STREAM-1:0] adv, tag_need, tlb_need;
  logic [ADDR_W-1:0]   s_addr [N_STREAM];
  logic [ADDR_W-1:0]   base   [N_STREAM];

  assign base[0] = src_addr_i;
  assign base[1] = dst_addr_i;

  blk_move_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (blk_op_e'(op_i)),
    .count_i   (count_i),
    .stall_i   (stall_i),
    .active_o  (active),
    .op_o      (op),
    .wr_phase_o(wr_phase),
    .load_o    (load),
    .src_adv_o (adv[0]),
    .dst_adv_o (adv[1]),
    .done_o    (done_o)
  );

  for (genvar g = 0; g < N_STREAM; g++) begin : g_stream
    blk_move_stream #(
      .ADDR_W(ADDR_W), .WORD_LG(WORD_LG), .LINE_LG(LINE_LG), .PAGE_LG(PAGE_LG)
    ) u_stream (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .addr_i    (base[g]),
      .adv_i     (adv[g]),
      .addr_o    (s_addr[g]),
      .tag_need_o(tag_need[g]),
      .tlb_need_o(tlb_need[g])
    );
  end

  logic sel;
  assign sel      = wr_phase;  // only a move ever enters the write phase
  assign addr_o   = s_addr[sel];
  assign rd_o     = active & ((op == OP_LOAD) | ((op == OP_MOVE) & ~wr_phase));
  assign wr_o     = active & ((op == OP_STORE) | ((op == OP_MOVE) & wr_phase));
  assign tag_en_o = active & tag_need[sel];
  assign tlb_en_o = active & tlb_need[sel];

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) && stall_i |=> $stable(addr_o) && $stable(rd_o) && $stable(wr_o)
                                  && $stable(tag_en_o) && $stable(tlb_en_o)); // R8
  AST_LOOKUP_ONLY_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_en_o || tlb_en_o |-> rd_o || wr_o); // R10
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_o && !wr_o); // R9
endmodule

// File: tb/blk_move_seq_test.sv
module blk_move_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, WL = 3, LL = 6, PL = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stall = 1'b0;
  logic [1:0] op = 2'b00;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] cnt = '0;
  logic [AW-1:0] addr;
  logic rd, wr, tag, tlb, done;
  int vecs = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_move_seq #(.ADDR_W(AW), .CNT_W(CW), .WORD_LG(WL), .LINE_LG(LL), .PAGE_LG(PL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .src_addr_i(src),
    .dst_addr_i(dst), .count_i(cnt), .stall_i(stall), .addr_o(addr), .rd_o(rd),
    .wr_o(wr), .tag_en_o(tag), .tlb_en_o(tlb), .done_o(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int n_units(input logic [AW-1:0] a0, input int n, input int lg);
    logic [AW-1:0] a, b;
    if (n == 0) return 0;
    a = {a0[AW-1:WL], {WL{1'b0}}};
    b = a + AW'((n - 1) * 8);
    return int'((b >> lg) - (a >> lg)) + 1;
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] sa, input logic [AW-1:0] da,
                        input int n, input int pct, input bit poke);
    int total, acc = 0, obs = 0, stl = 0, tags = 0, tlbs = 0;
    int exp_tags, exp_tlbs;
    logic [AW-1:0] ea_s, ea_d, ls = '0, ld = '0;
    bit fs = 1, fd = 1, was_stall = 0, seen_done = 0;
    logic [AW-1:0] h_addr = '0;
    logic [3:0] h_fl = '0;
    string rq;
    total = (o == 2'b00) ? 0 : ((o == 2'b11) ? 2 * n : n);
    rq = (o == 2'b01) ? "R2" : (o == 2'b10) ? "R3" : (o == 2'b11) ? "R4" : "R10";
    ea_s = {sa[AW-1:WL], {WL{1'b0}}};
    ea_d = {da[AW-1:WL], {WL{1'b0}}};
    @(negedge clk);
    start = 1'b1; op = o; src = sa; dst = da; cnt = CW'(n); stall = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (obs < 5000) begin
      bit ph, use_d, e_rd, e_wr, e_tag, e_tlb;
      logic [AW-1:0] ea, lp;
      bit fp;
      obs++;
      if (was_stall) chk({addr, rd, wr, tag, tlb} == {h_addr, h_fl}, "R8",
                         64'({addr, rd, wr, tag, tlb}), 64'({h_addr, h_fl}));
      if (done) begin
        seen_done = 1;
        chk(!rd && !wr, "R9", 64'({rd, wr}), 64'd0);
        break;
      end
      start = 1'b0;
      if (poke && obs == 3) begin
        start = 1'b1; op = 2'b00; src = 32'h4000; dst = 32'h8000; cnt = '0;
      end
      ph = (o == 2'b11) && (acc % 2 == 1);
      use_d = ph;
      e_rd = (o == 2'b01) || (o == 2'b11 && !ph);
      e_wr = (o == 2'b10) || (o == 2'b11 && ph);
      ea = use_d ? ea_d : ea_s;
      lp = use_d ? ld : ls;
      fp = use_d ? fd : fs;
      e_tag = fp || ((ea >> LL) != (lp >> LL));
      e_tlb = fp || ((ea >> PL) != (lp >> PL));
      chk(rd == e_rd && wr == e_wr, poke ? "R11" : (rd || wr) ? rq : "R7",
          64'({rd, wr}), 64'({e_rd, e_wr}));
      chk(addr == ea, rq, 64'(addr), 64'(ea));
      chk(tag == e_tag, "R5", 64'(tag), 64'(e_tag));
      chk(tlb == e_tlb, "R6", 64'(tlb), 64'(e_tlb));
      stall = ($urandom_range(99) < pct);
      if (!stall) begin
        acc++;
        tags += int'(tag);
        tlbs += int'(tlb);
        if (use_d) begin ld = ea_d; fd = 0; ea_d += 8; end
        else       begin ls = ea_s; fs = 0; ea_s += 8; end
      end else begin
        stl++;
        h_addr = addr; h_fl = {rd, wr, tag, tlb};
      end
      was_stall = stall;
      @(negedge clk);
    end
    stall = 1'b0; start = 1'b0;
    chk(seen_done, "R9", 64'(seen_done), 64'd1);
    chk(acc == total, (total == 0) ? "R10" : rq, 64'(acc), 64'(total));
    chk(obs == total + stl + 1, "R7", 64'(obs), 64'(total + stl + 1));
    exp_tags = (o == 2'b00) ? 0 : n_units(sa, n, LL) + ((o == 2'b11) ? n_units(da, n, LL) : 0);
    exp_tlbs = (o == 2'b00) ? 0 : n_units(sa, n, PL) + ((o == 2'b11) ? n_units(da, n, PL) : 0);
    chk(tags == exp_tags, "R5", 64'(tags), 64'(exp_tags));
    chk(tlbs == exp_tlbs, "R6", 64'(tlbs), 64'(exp_tlbs));
    @(negedge clk);
    chk(!done && !rd && !wr && !tag && !tlb, "R9", 64'({done, rd, wr, tag, tlb}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({rd, wr, tag, tlb, done} == 5'b0, "R1", 64'({rd, wr, tag, tlb, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd, wr, tag, tlb, done} == 5'b0, "R1", 64'({rd, wr, tag, tlb, done}), 64'd0);
    // directed corners
    run_op(2'b01, 32'h0000_0038, '0, 10, 0, 0);          // line crossing, no stall (R2, R7)
    run_op(2'b10, 32'h0000_01F0, '0, 12, 0, 0);          // page crossing (R3, R6)
    run_op(2'b11, 32'h0000_0100, 32'h0000_03E8, 40, 0, 0); // move, streams cross apart (R4)
    run_op(2'b01, 32'h0000_0000, '0, 0, 0, 0);           // zero count (R10)
    run_op(2'b00, 32'h0000_0040, '0, 5, 0, 0);           // no-op code (R10)
    run_op(2'b11, 32'h0000_0A07, 32'h0000_1235, 9, 50, 0); // unaligned bases, stalls (R8)
    run_op(2'b01, 32'h0000_0200, '0, 16, 0, 1);          // start while busy (R11)
    run_op(2'b10, 32'h0000_0008, '0, 1, 70, 0);          // single word under stall
    for (int i = 0; i < 40; i++) begin
      logic [1:0] ro;
      ro = 2'($urandom_range(3));
      run_op(ro, AW'($urandom_range(16'hFFFF)), AW'($urandom_range(16'hFFFF)),
             int'($urandom_range(100)), int'($urandom_range(40)), (i % 7) == 3);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule